// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block watches the instruction fetch stream and compares every valid fetch against four programmable breakpoint channels. Each channel holds a control word (enable and address-space filter enable), a compare address, a per-bit ignore mask and an 8-bit address-space identifier. When an enabled channel matches a valid fetch, the unit raises a registered break request toward the debug logic. It also sets a sticky per-channel status bit that debug software later clears.

The lowest bit of the fetch address carries the compressed-ISA mode flag. Because the ignore mask covers that bit, a breakpoint can be restricted to one instruction mode or opened to both. A small word-wide register port is used to program the channels and read back the status word. The read data is combinational from the register address.

Register address map (`reg_addr`, 5 bits): when bit 4 is 0 the status word is selected. When bit 4 is 1, bits 3:2 pick the channel and bits 1:0 pick the register: 0 control, 1 compare address, 2 ignore mask, 3 identifier. Control bit 0 is enable and bit 1 is identifier-filter enable. All other control bits are ignored and read as zero.

Top module: `ibrk_unit`

## Requirements
- R1: After a synchronous active-low reset, `brk_req` is 0, all status match bits are 0 and every channel register reads 0.
- R2: For an enabled channel, a valid fetch matches when every address bit whose mask bit is 0 equals the compare address; with an all-zero mask only the exact address matches.
- R3: Address bit 0 is the mode flag: with mask bit 0 clear a channel fires only in the mode stored in compare bit 0, with mask bit 0 set it fires in either mode.
- R4: When control bit 1 is set, a match also needs `cur_asid` to equal the channel identifier; when it is clear the identifier plays no part.
- R5: A channel never matches while its control bit 0 is clear or while `fetch_valid` is low.
- R6: `brk_req` is high in the cycle after any channel matched and low in the cycle after no channel matched.
- R7: A matching channel sets its status bit (status bits 3:0, bit n for channel n) on the next edge. The bit stays set until a status write with 1 in that position. A match in the same cycle as that write leaves it set.
- R8: The status word reads channel count 4 in bits 27:24 and the match bits in bits 3:0; every other bit except 30 reads 0.
- R9: Identifier registers keep only 8 bits; bits 31:8 read back as zero whatever was written.
- R10: Status bit 30 reads the value of parameter `HAS_TLB` (1 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Fetch address, bit 0 is the compressed-ISA mode flag |
| cur_asid | input | 8 | Current address-space identifier |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| brk_req | output | 1 | Registered break request |

## Verification
Random channel setups use sparse ignore masks, and fetch addresses are drawn either near a channel's compare value or fully at random. This separates masked-bit don't-cares from true mismatches. The current identifier is drawn either equal to a channel's identifier or random, so the filter-on and filter-off cases are told apart. Directed fetches flip only address bit 0 to show mode selection, and fetch with enable or valid low. Status clears are issued in the same cycle as a fresh match, in a cycle with no match, and not at all, which separates set priority from plain clearing and from holding.

// File: rtl/ibrk_pkg.sv
// Shared constants and types for the instruction breakpoint unit.
// Assumes a 32-bit fetch address and an 8-bit address-space identifier.
package ibrk_pkg;
    parameter int ADDR_W  = 32;
    parameter int ASID_W  = 8;
    parameter int DATA_W  = 32;
    parameter int SEL_W   = 2;

    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
    localparam logic [SEL_W-1:0] SEL_ADDR = 2'd1;
    localparam logic [SEL_W-1:0] SEL_MASK = 2'd2;
    localparam logic [SEL_W-1:0] SEL_ASID = 2'd3;

    typedef struct packed {
        logic              en;
        logic              asid_use;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] mask;
        logic [ASID_W-1:0] asid;
    } ibrk_cfg_t;
endpackage

// File: rtl/ibrk_channel.sv
// One breakpoint channel: holds its configuration registers and flags a
// combinational hit for the current fetch. Assumes the write strobe is
// already decoded for this channel.
module ibrk_channel
    import ibrk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ASID_W-1:0] cur_asid,
    output ibrk_cfg_t         cfg,
    output logic              hit
);
    logic addr_ok;
    logic asid_ok;

    // Register writes into the selected configuration field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    cfg.en       <= wdata[0];
                    cfg.asid_use <= wdata[1];
                end
                SEL_ADDR: cfg.addr <= wdata[ADDR_W-1:0];
                SEL_MASK: cfg.mask <= wdata[ADDR_W-1:0];
                default:  cfg.asid <= wdata[ASID_W-1:0];
            endcase
        end
    end

    // Masked address compare (bit 0 is the mode flag) and identifier filter.
    always_comb begin
        addr_ok = (((fetch_addr ^ cfg.addr) & ~cfg.mask) == '0);
        asid_ok = !cfg.asid_use || (cur_asid == cfg.asid);
        hit     = fetch_valid && cfg.en && addr_ok && asid_ok;
    end

    a_r5_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid || !cfg.en) |-> !hit);
    a_r4_asid_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.asid_use && (cur_asid != cfg.asid)) |-> !hit);
endmodule

// File: rtl/ibrk_status.sv
// Sticky per-channel match bits with write-one-to-clear, and the registered
// break request. Assumes hits arrive combinationally in the same cycle.
module ibrk_status #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit,
    input  logic              clr_en,
    input  logic [NUM_CH-1:0] clr_bits,
    output logic [NUM_CH-1:0] sticky,
    output logic              brk_req
);
    logic [NUM_CH-1:0] clr_mask;

    // Effective clear vector for this cycle.
    always_comb clr_mask = clr_en ? clr_bits : '0;

    // Sticky bits: new matches win over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky <= '0;
        else        sticky <= (sticky & ~clr_mask) | hit;
    end

    // Break request registered once from the OR of this cycle's hits.
    always_ff @(posedge clk) begin
        if (!rst_n) brk_req <= 1'b0;
        else        brk_req <= |hit;
    end

    a_r7_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(sticky) & ~$past(clr_mask)) & ~sticky) == '0));
    a_r7_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky & $past(hit)) == $past(hit)));
endmodule

// File: rtl/ibrk_unit.sv
// Instruction address breakpoint unit top: decodes the register port,
// instantiates the channels and the status logic, and muxes read data.
// Assumes single-cycle register writes and a combinational read path.
module ibrk_unit
    import ibrk_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter bit HAS_TLB = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_addr,
    input  logic [7:0]  cur_asid,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        brk_req
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int RA_MSB = CH_W + SEL_W;

    ibrk_cfg_t          cfg [NUM_CH];
    logic [NUM_CH-1:0]  hit;
    logic [NUM_CH-1:0]  sticky;
    logic               is_chan;
    logic [CH_W-1:0]    ch_idx;
    logic [SEL_W-1:0]   sel;
    logic               status_wr;

    // Split the register address into region, channel and field.
    always_comb begin
        is_chan   = reg_addr[RA_MSB];
        ch_idx    = reg_addr[RA_MSB-1:SEL_W];
        sel       = reg_addr[SEL_W-1:0];
        status_wr = reg_wr && !is_chan;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ibrk_channel u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (reg_wr && is_chan && (ch_idx == CH_W'(i))),
            .wr_sel      (sel),
            .wdata       (reg_wdata),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .cur_asid    (cur_asid),
            .cfg         (cfg[i]),
            .hit         (hit[i])
        );
    end

    ibrk_status #(.NUM_CH(NUM_CH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .clr_en   (status_wr),
        .clr_bits (reg_wdata[NUM_CH-1:0]),
        .sticky   (sticky),
        .brk_req  (brk_req)
    );

    // Read mux: status word or one field of the selected channel.
    always_comb begin
        reg_rdata = '0;
        if (!is_chan) begin
            reg_rdata[30]            = HAS_TLB;
            reg_rdata[27:24]         = 4'(NUM_CH);
            reg_rdata[NUM_CH-1:0]    = sticky;
        end else begin
            case (sel)
                SEL_CTRL: reg_rdata[1:0]        = {cfg[ch_idx].asid_use, cfg[ch_idx].en};
                SEL_ADDR: reg_rdata[ADDR_W-1:0] = cfg[ch_idx].addr;
                SEL_MASK: reg_rdata[ADDR_W-1:0] = cfg[ch_idx].mask;
                default:  reg_rdata[ASID_W-1:0] = cfg[ch_idx].asid;
            endcase
        end
    end

    a_r6_req_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> brk_req);
    a_r6_quiet_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hit) |=> !brk_req);
    a_r9_asid_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (is_chan && sel == SEL_ASID) |-> (reg_rdata[31:ASID_W] == '0));
endmodule

// File: tb/ibrk_unit_test.sv
module ibrk_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam bit HAS_TLB    = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [7:0]  cur_asid = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        brk_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic        sh_en   [4];
    logic        sh_use  [4];
    logic [31:0] sh_addr [4];
    logic [31:0] sh_mask [4];
    logic [7:0]  sh_asid [4];
    logic [3:0]  st;

    ibrk_unit #(.NUM_CH(4), .HAS_TLB(HAS_TLB)) uut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .cur_asid(cur_asid), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .brk_req(brk_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] status_word(input logic [3:0] s);
        return {1'b0, HAS_TLB, 2'b00, 4'd4, 20'd0, s};
    endfunction

    function automatic logic [3:0] exp_hits(input logic v, input logic [31:0] a,
                                            input logic [7:0] as);
        logic [3:0] h;
        for (int j = 0; j < 4; j++)
            h[j] = v && sh_en[j] && (((a ^ sh_addr[j]) & ~sh_mask[j]) == 0)
                   && (!sh_use[j] || as == sh_asid[j]);
        return h;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        fetch_valid = 0; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_addr = 0;
        if (a[4]) begin
            case (a[1:0])
                2'd0: begin sh_en[a[3:2]] = d[0]; sh_use[a[3:2]] = d[1]; end
                2'd1: sh_addr[a[3:2]] = d;
                2'd2: sh_mask[a[3:2]] = d;
                default: sh_asid[a[3:2]] = d[7:0];
            endcase
        end else begin
            st = st & ~d[3:0];
        end
    endtask

    task automatic read_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_wr = 0; reg_addr = a;
        #1 check(tag, reg_rdata, exp);
        reg_addr = 0;
    endtask

    task automatic setup(input int j, input logic [31:0] ctrl, input logic [31:0] ad,
                         input logic [31:0] mk, input logic [31:0] as);
        write_reg({1'b1, 2'(j), 2'd1}, ad);
        write_reg({1'b1, 2'(j), 2'd2}, mk);
        write_reg({1'b1, 2'(j), 2'd3}, as);
        write_reg({1'b1, 2'(j), 2'd0}, ctrl);
    endtask

    task automatic run_cycle(input string tag, input logic v, input logic [31:0] a,
                             input logic [7:0] as, input logic clr, input logic [3:0] cm);
        logic [3:0] eh;
        @(negedge clk);
        fetch_valid = v; fetch_addr = a; cur_asid = as;
        reg_wr = clr; reg_addr = 5'd0; reg_wdata = {28'd0, cm};
        eh = exp_hits(v, a, as);
        @(posedge clk);
        @(negedge clk);
        fetch_valid = 0; reg_wr = 0;
        st = (st & ~(clr ? cm : 4'd0)) | eh;
        #1;
        check({tag, " R6 brk_req"}, 32'(brk_req), 32'(|eh));
        check({tag, " R7 status"}, reg_rdata, status_word(st));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int j = 0; j < 4; j++) begin
            sh_en[j] = 0; sh_use[j] = 0; sh_addr[j] = 0; sh_mask[j] = 0; sh_asid[j] = 0;
        end
        st = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 / R8 / R10: reset state and status layout
        check("R1 brk_req reset", 32'(brk_req), 32'd0);
        read_chk("R1 R8 R10 status reset", 5'h00, 32'h4400_0000);
        read_chk("R1 ch0 ctrl reset", 5'h10, 32'd0);
        read_chk("R1 ch3 addr reset", 5'h1D, 32'd0);

        // R9: identifier keeps 8 bits
        write_reg(5'h17, 32'hFFFF_FFA5);
        read_chk("R9 asid upper zero", 5'h17, 32'h0000_00A5);
        read_chk("R1 ctrl ignores upper bits", 5'h10, 32'd0);

        // R2: exact match with zero mask
        setup(0, 32'hFFFF_FFF1, 32'h0000_1000, 32'd0, 32'd0);
        read_chk("R2 ctrl readback", 5'h10, 32'd1);
        run_cycle("R2 exact hit", 1, 32'h0000_1000, 8'd0, 0, 0);
        run_cycle("R2 near miss", 1, 32'h0000_1004, 8'd0, 1, 4'hF);

        // R3: mode bit selection
        setup(0, 32'd1, 32'h0000_2001, 32'd0, 32'd0);
        run_cycle("R3 other mode miss", 1, 32'h0000_2000, 8'd0, 0, 0);
        run_cycle("R3 same mode hit", 1, 32'h0000_2001, 8'd0, 1, 4'h1);
        write_reg(5'h12, 32'd1);
        run_cycle("R3 either mode hit", 1, 32'h0000_2000, 8'd0, 1, 4'h1);

        // R4: identifier filter
        setup(1, 32'd3, 32'h0000_3000, 32'd0, 32'd5);
        run_cycle("R4 asid equal hit", 1, 32'h0000_3000, 8'd5, 1, 4'hF);
        run_cycle("R4 asid differ miss", 1, 32'h0000_3000, 8'd6, 1, 4'hF);
        write_reg(5'h14, 32'd1);
        run_cycle("R4 filter off hit", 1, 32'h0000_3000, 8'd6, 1, 4'hF);

        // R5: enable and valid gating
        run_cycle("R5 valid low", 0, 32'h0000_3000, 8'd6, 1, 4'hF);
        write_reg(5'h14, 32'd0);
        run_cycle("R5 disabled", 1, 32'h0000_3000, 8'd6, 0, 0);

        // R7: set priority, hold, clear
        write_reg(5'h14, 32'd1);
        run_cycle("R7 set", 1, 32'h0000_3000, 8'd0, 0, 0);
        run_cycle("R7 hold", 0, 32'h0, 8'd0, 0, 0);
        run_cycle("R7 clear with hit", 1, 32'h0000_3000, 8'd0, 1, 4'h2);
        run_cycle("R7 clear alone", 0, 32'h0, 8'd0, 1, 4'h2);

        // Random phase covering R2 R3 R4 R5 R6 R7
        for (int round = 0; round < 4; round++) begin
            for (int j = 0; j < 4; j++)
                setup(j, $urandom, $urandom, $urandom & $urandom & $urandom, $urandom);
            for (int n = 0; n < 250; n++) begin
                int j;
                logic [31:0] a;
                logic [7:0] as;
                j  = int'($urandom % 4);
                a  = ($urandom % 4 != 0) ? (sh_addr[j] ^ ($urandom & sh_mask[j]) ^
                     (($urandom % 5 == 0) ? 32'd1 : 32'd0)) : $urandom;
                as = ($urandom % 2 != 0) ? sh_asid[j] : 8'($urandom);
                run_cycle("R2 R4 random", ($urandom % 8) != 0, a, as,
                          ($urandom % 5) == 0, 4'($urandom));
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule